// File: doc/BRIEF.md
# Dataflow Token Logic Cell

This block is one tile of a programmable dataflow fabric. Single-bit tokens enter and leave on four sides (north, east, south, west). Every channel uses a valid/ready handshake, and a token moves only on a clock edge where valid and ready are both high. Inside the cell there are the following units:

- a 4-input lookup-table function unit that joins its operands into one result token;
- two copy units, each of which fans one token out to a set of sides;
- three constant sources;
- one sink that discards whatever it is fed.

A 96-bit static configuration word picks each unit's producer and holds the table contents. The word is loaded with a parallel strobe while the datapath is in reset.

Back-pressure works differently in each part of the cell:

- **Direct routes.** A direct route from a producer to a side output is combinational in both valid and ready.
- **Function unit and copy units.** Each of these holds exactly one token in a register. Its input ready depends only on whether that register is occupied, never on the ready of the downstream consumer. A held output keeps its valid and data stable until it is accepted.

The tile is configured so that each producer has at most one consumer. The copy units exist to provide fan-out.

Top module: `token_cell`

## Requirements
- R1: After reset with an all-zero configuration, every `side_out_vld` bit and every `side_in_rdy` bit is low, even while all `side_in_vld` and `side_out_rdy` bits are high.
- R2: `cfg_word` is captured only on a clock edge where `cfg_load` is high. Producer codes are 4 bits: 0 = none, 1..4 = side input N,E,S,W, 5 = function unit, 6..8 = source 0..2, and 9..15 act as none. Side bit index is N=0, E=1, S=2, W=3. The word is laid out as follows:
  - bits 15:0 hold the table;
  - operand k's producer is at bits 16+4k;
  - side output j's direct producer is at bits 32+4j;
  - copy c's producer is at bits 48+8c, and its 4-bit side mask is at bits 52+8c;
  - the sink's producer is at bits 67:64;
  - source s's constant is at bit 68+s;
  - bits 95:71 are ignored.
- R3: A side output with a direct producer that no copy unit claims carries that producer's valid and data in the same cycle, and the producer's ready equals that side's `side_out_rdy` in the same cycle.
- R4: When the function unit fires, it produces one token the next cycle with value table[{op3,op2,op1,op0}].
- R5: The function unit fires only in a cycle where every used operand is valid. It then accepts all of them in that same cycle, and until then it leaves every one of them unaccepted.
- R6: An operand whose code is 0 reads as 0 and is never waited for.
- R7: The function unit holds at most one result. While the result is held it accepts no operands, and it is empty in the cycle after the result is taken.
- R8: A copy unit accepts a token only when it is empty. It offers the token to each side in its mask, and each side receives it exactly once. The next token is accepted only after every masked side has taken the current one.
- R9: A side in a copy unit's mask is driven by that copy unit, and its direct producer code is ignored. Where both copy masks include a side, copy 0 owns it.
- R10: A source's output is always valid and carries its configured constant.
- R11: The sink is always ready and its tokens appear on no output.
- R12: A held function-unit or copy-unit output keeps valid high and data unchanged until its consumer is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low datapath reset |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_word | input | 96 | Configuration word |
| side_in_vld | input | 4 | Input token valid per side (N,E,S,W) |
| side_in_dat | input | 4 | Input token data per side |
| side_in_rdy | output | 4 | Input ready per side |
| side_out_vld | output | 4 | Output token valid per side |
| side_out_dat | output | 4 | Output token data per side |
| side_out_rdy | input | 4 | Output ready per side |

## Verification
The assertions watch the following on every cycle:
- the function unit's stable hold under back-pressure;
- its empty state right after its result is taken;
- a copy unit never re-offering a token to a side that already took it;
- a copy unit holding each pending copy steady.

Several behaviours need the bench's scenarios: the table lookup, the join that waits for a late operand, unused operands reading as zero, copy-mask override, constant sources, the discarding sink, and combinational direct routing. Each of these depends on a particular configuration and on a particular order of token arrivals.

// File: rtl/token_cell_pkg.sv
package token_cell_pkg;
  localparam int SIDES    = 4;
  localparam int LUT_K    = 4;
  localparam int N_SRC    = 3;
  localparam int N_COPY   = 2;
  localparam int SEL_W    = 4;
  localparam int CFG_W    = 96;
  localparam int TABLE_W  = 1 << LUT_K;

  localparam int P_SIDE0  = 1;
  localparam int P_LUT    = P_SIDE0 + SIDES;
  localparam int P_SRC0   = P_LUT + 1;
  localparam int N_PROD   = P_SRC0 + N_SRC;

  localparam int OFF_TABLE = 0;
  localparam int OFF_LSEL  = OFF_TABLE + TABLE_W;
  localparam int OFF_OSEL  = OFF_LSEL + LUT_K * SEL_W;
  localparam int CP_STRIDE = SEL_W + SIDES;
  localparam int OFF_COPY  = OFF_OSEL + SIDES * SEL_W;
  localparam int OFF_SINK  = OFF_COPY + N_COPY * CP_STRIDE;
  localparam int OFF_CONST = OFF_SINK + SEL_W;
  localparam int OFF_END   = OFF_CONST + N_SRC;

  typedef logic [SEL_W-1:0] prod_sel_t;

  function automatic logic sel_ok(prod_sel_t s);
    return (s != '0) && (s < SEL_W'(N_PROD));
  endfunction
endpackage

// File: rtl/token_lut_unit.sv
module token_lut_unit #(
  parameter int K = token_cell_pkg::LUT_K,
  localparam int TW = 1 << K
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] table_bits,
  input  logic [K-1:0]  op_used,
  input  logic [K-1:0]  op_vld,
  input  logic [K-1:0]  op_dat,
  output logic          fire,
  output logic          res_vld,
  output logic          res_dat,
  input  logic          res_rdy
);
  logic         full_q, dat_q;
  logic [K-1:0] idx;

  assign idx     = op_dat & op_used;
  assign fire    = !full_q && (&(op_vld | ~op_used));
  assign res_vld = full_q;
  assign res_dat = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      dat_q  <= 1'b0;
    end else if (fire) begin
      full_q <= 1'b1;
      dat_q  <= table_bits[idx];
    end else if (full_q && res_rdy) begin
      full_q <= 1'b0;
    end
  end

  // R12: result held steady under back-pressure
  a_r12_lut_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && !res_rdy |=> res_vld && $stable(res_dat));
  // R7: buffer is empty the cycle after its token leaves
  a_r7_lut_drain: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && res_rdy |=> !res_vld);
endmodule

// File: rtl/token_copy_unit.sv
module token_copy_unit #(
  parameter int D = token_cell_pkg::SIDES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [D-1:0] dst_mask,
  input  logic         in_vld,
  input  logic         in_dat,
  output logic         in_rdy,
  output logic [D-1:0] dst_vld,
  output logic         dst_dat,
  input  logic [D-1:0] dst_rdy
);
  logic         full_q, dat_q;
  logic [D-1:0] done_q, acc;
  logic         all_done;

  assign in_rdy   = !full_q;
  assign dst_vld  = {D{full_q}} & dst_mask & ~done_q;
  assign dst_dat  = dat_q;
  assign acc      = dst_vld & dst_rdy;
  assign all_done = &(done_q | acc | ~dst_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      dat_q  <= 1'b0;
      done_q <= '0;
    end else if (!full_q) begin
      if (in_vld) begin
        full_q <= 1'b1;
        dat_q  <= in_dat;
        done_q <= '0;
      end
    end else if (all_done) begin
      full_q <= 1'b0;
      done_q <= '0;
    end else begin
      done_q <= done_q | acc;
    end
  end

  for (genvar d = 0; d < D; d++) begin : g_chk
    // R8: a side that took the copy is not offered it again
    a_r8_no_resend: assert property (@(posedge clk) disable iff (!rst_n)
      dst_vld[d] && dst_rdy[d] |=> !dst_vld[d]);
    // R12: pending copy held steady
    a_r12_copy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dst_vld[d] && !dst_rdy[d] && $stable(dst_mask) |=> dst_vld[d] && $stable(dst_dat));
  end
endmodule

// File: rtl/token_cell.sv
module token_cell
  import token_cell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [SIDES-1:0] side_in_vld,
  input  logic [SIDES-1:0] side_in_dat,
  output logic [SIDES-1:0] side_in_rdy,
  output logic [SIDES-1:0] side_out_vld,
  output logic [SIDES-1:0] side_out_dat,
  input  logic [SIDES-1:0] side_out_rdy
);
  logic [CFG_W-1:0]  cfg_q;
  logic [N_PROD-1:0] prod_vld, prod_dat, prod_rdy;
  prod_sel_t         lsel [LUT_K];
  prod_sel_t         osel [SIDES];
  prod_sel_t         csel [N_COPY];
  logic [SIDES-1:0]  raw_mask [N_COPY];
  logic [SIDES-1:0]  eff_mask [N_COPY];
  logic [SIDES-1:0]  claimed;
  prod_sel_t         sink_sel;
  logic [LUT_K-1:0]  op_used, op_vld, op_dat;
  logic              lut_fire, lut_vld, lut_dat;
  logic [N_COPY-1:0] cp_in_vld, cp_in_dat, cp_in_rdy, cp_dat;
  logic [SIDES-1:0]  cp_dvld [N_COPY];
  logic              cfg_unused;

  always_ff @(posedge clk) begin
    if (cfg_load) cfg_q <= cfg_word;
  end

  assign sink_sel   = cfg_q[OFF_SINK +: SEL_W];
  assign cfg_unused = ^{cfg_q[CFG_W-1:OFF_END], prod_rdy[0], prod_rdy[N_PROD-1:P_SRC0]};

  for (genvar k = 0; k < LUT_K; k++) begin : g_op
    assign lsel[k]    = cfg_q[OFF_LSEL + k*SEL_W +: SEL_W];
    assign op_used[k] = sel_ok(lsel[k]);
    assign op_vld[k]  = op_used[k] ? prod_vld[lsel[k]] : 1'b0;
    assign op_dat[k]  = op_used[k] ? prod_dat[lsel[k]] : 1'b0;
  end

  for (genvar j = 0; j < SIDES; j++) begin : g_osel
    assign osel[j] = cfg_q[OFF_OSEL + j*SEL_W +: SEL_W];
  end

  // producer table: none, side inputs, function unit, constant sources
  always_comb begin
    prod_vld = '0;
    prod_dat = '0;
    for (int i = 0; i < SIDES; i++) begin
      prod_vld[P_SIDE0+i] = side_in_vld[i];
      prod_dat[P_SIDE0+i] = side_in_dat[i];
    end
    prod_vld[P_LUT] = lut_vld;
    prod_dat[P_LUT] = lut_dat;
    for (int s = 0; s < N_SRC; s++) begin
      prod_vld[P_SRC0+s] = 1'b1;
      prod_dat[P_SRC0+s] = cfg_q[OFF_CONST+s];
    end
  end

  token_lut_unit #(.K(LUT_K)) u_lut (
    .clk(clk), .rst_n(rst_n),
    .table_bits(cfg_q[OFF_TABLE +: TABLE_W]),
    .op_used(op_used), .op_vld(op_vld), .op_dat(op_dat),
    .fire(lut_fire),
    .res_vld(lut_vld), .res_dat(lut_dat), .res_rdy(prod_rdy[P_LUT])
  );

  // copy side ownership: earlier copy unit wins overlapping sides
  always_comb begin
    logic [SIDES-1:0] taken;
    taken = '0;
    for (int c = 0; c < N_COPY; c++) begin
      eff_mask[c] = raw_mask[c] & ~taken;
      taken       = taken | raw_mask[c];
    end
    claimed = taken;
  end

  for (genvar c = 0; c < N_COPY; c++) begin : g_copy
    assign csel[c]     = cfg_q[OFF_COPY + c*CP_STRIDE +: SEL_W];
    assign raw_mask[c] = cfg_q[OFF_COPY + c*CP_STRIDE + SEL_W +: SIDES];
    assign cp_in_vld[c] = sel_ok(csel[c]) ? prod_vld[csel[c]] : 1'b0;
    assign cp_in_dat[c] = sel_ok(csel[c]) ? prod_dat[csel[c]] : 1'b0;

    token_copy_unit #(.D(SIDES)) u_copy (
      .clk(clk), .rst_n(rst_n),
      .dst_mask(eff_mask[c]),
      .in_vld(cp_in_vld[c]), .in_dat(cp_in_dat[c]), .in_rdy(cp_in_rdy[c]),
      .dst_vld(cp_dvld[c]), .dst_dat(cp_dat[c]),
      .dst_rdy(side_out_rdy & eff_mask[c])
    );
  end

  // ready back to producers from whichever consumer selects them
  always_comb begin
    prod_rdy = '0;
    for (int k = 0; k < LUT_K; k++)
      if (op_used[k]) prod_rdy[lsel[k]] = prod_rdy[lsel[k]] | lut_fire;
    for (int c = 0; c < N_COPY; c++)
      if (sel_ok(csel[c])) prod_rdy[csel[c]] = prod_rdy[csel[c]] | cp_in_rdy[c];
    if (sel_ok(sink_sel)) prod_rdy[sink_sel] = 1'b1;
    for (int j = 0; j < SIDES; j++)
      if (!claimed[j] && sel_ok(osel[j]))
        prod_rdy[osel[j]] = prod_rdy[osel[j]] | side_out_rdy[j];
  end

  always_comb begin
    for (int j = 0; j < SIDES; j++) begin
      side_out_vld[j] = 1'b0;
      side_out_dat[j] = 1'b0;
      if (claimed[j]) begin
        for (int c = 0; c < N_COPY; c++)
          if (eff_mask[c][j]) begin
            side_out_vld[j] = cp_dvld[c][j];
            side_out_dat[j] = cp_dat[c];
          end
      end else if (sel_ok(osel[j])) begin
        side_out_vld[j] = prod_vld[osel[j]];
        side_out_dat[j] = prod_dat[osel[j]];
      end
    end
    for (int i = 0; i < SIDES; i++) side_in_rdy[i] = prod_rdy[P_SIDE0+i];
  end
endmodule

// File: tb/token_cell_tb_top.sv
module token_cell_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [95:0] cfg_word = '0;
  logic [95:0] cfg_v;
  logic [3:0]  side_in_vld = '0, side_in_dat = '0, side_in_rdy;
  logic [3:0]  side_out_vld, side_out_dat, side_out_rdy = '0;

  int n_chk = 0, n_bad = 0;
  bit q [4][$];
  bit const_on [4];
  bit const_val [4];
  int const_cnt [4];
  string side_req [4];

  always #10 clk = ~clk;

  token_cell dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .side_in_vld(side_in_vld), .side_in_dat(side_in_dat), .side_in_rdy(side_in_rdy),
    .side_out_vld(side_out_vld), .side_out_dat(side_out_dat), .side_out_rdy(side_out_rdy)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // monitor: pops expected tokens as each side output transfers
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        for (int j = 0; j < 4; j++) begin
          if (side_out_vld[j] && side_out_rdy[j]) begin
            if (const_on[j]) begin
              const_cnt[j]++;
              check(side_out_dat[j] == const_val[j], side_req[j], side_out_dat[j], const_val[j]);
            end else if (q[j].size() == 0) begin
              check(1'b0, {side_req[j], " unexpected token"}, side_out_dat[j], -1);
            end else begin
              bit e;
              e = q[j].pop_front();
              check(side_out_dat[j] == e, side_req[j], side_out_dat[j], e);
            end
          end
        end
      end
    end
  end

  task automatic reconfig();
    side_out_rdy = '0;
    side_in_vld = '0;
    rst_n = 1'b0;
    for (int j = 0; j < 4; j++) begin const_on[j] = 0; const_cnt[j] = 0; end
    @(negedge clk);
    cfg_word = cfg_v;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_pair(bit a, bit b);
    q[2].push_back(a ^ b);
    side_in_dat[1:0] = {b, a};
    side_in_vld[1:0] = 2'b11;
    while (1) begin
      #1;
      if (side_in_rdy[0]) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    side_in_vld[1:0] = 2'b00;
  endtask

  task automatic wait_idle(int n, string req);
    repeat (n) @(negedge clk);
    for (int j = 0; j < 4; j++) check(q[j].size() == 0, req, q[j].size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    for (int j = 0; j < 4; j++) side_req[j] = "R3";

    // ---- R1: idle after reset with empty configuration
    cfg_v = '0;
    reconfig();
    side_in_vld = 4'hF;
    side_out_rdy = 4'hF;
    #3;
    check(side_out_vld == 4'h0, "R1 out_vld", side_out_vld, 0);
    check(side_in_rdy == 4'h0, "R1 in_rdy", side_in_rdy, 0);

    // ---- function unit: op0=N, op1=E, ops 2,3 unused; result to S; S input direct to W
    cfg_v = '0;
    cfg_v[15:0]  = 16'hFFF6;
    cfg_v[19:16] = 4'd1;
    cfg_v[23:20] = 4'd2;
    cfg_v[43:40] = 4'd5;
    cfg_v[47:44] = 4'd3;
    reconfig();
    side_req[2] = "R4";
    side_req[3] = "R3";
    side_out_rdy = 4'b0111;
    // R3 direct route, combinational both ways
    q[3].push_back(1'b1);
    side_in_dat[2] = 1'b1; side_in_vld[2] = 1'b1;
    #3;
    check(side_out_vld[3] == 1'b1 && side_out_dat[3] == 1'b1, "R3 direct valid/data", side_out_vld[3], 1);
    check(side_in_rdy[2] == 1'b0, "R3 ready follows side", side_in_rdy[2], 0);
    @(negedge clk);
    side_out_rdy[3] = 1'b1;
    #1;
    check(side_in_rdy[2] == 1'b1, "R3 ready passes", side_in_rdy[2], 1);
    @(negedge clk);
    side_in_vld[2] = 1'b0;
    // R4 / R6: table lookup with unused high operands reading 0
    send_pair(0, 0);
    send_pair(1, 0);
    send_pair(0, 1);
    send_pair(1, 1);
    wait_idle(4, "R4 all results");
    // R5: late operand
    side_in_dat[0] = 1'b1; side_in_vld[0] = 1'b1;
    repeat (3) begin
      #3;
      check(side_in_rdy[0] == 1'b0, "R5 waits for E", side_in_rdy[0], 0);
      check(side_out_vld[2] == 1'b0, "R5 no early result", side_out_vld[2], 0);
      @(negedge clk);
    end
    q[2].push_back(1'b0);
    side_in_dat[1] = 1'b1; side_in_vld[1] = 1'b1;
    #1;
    check(side_in_rdy[1:0] == 2'b11, "R5 joint accept", side_in_rdy[1:0], 3);
    @(posedge clk); @(negedge clk);
    side_in_vld[1:0] = 2'b00;
    wait_idle(3, "R5 result");
    // R7 / R12: held result under back-pressure
    side_out_rdy[2] = 1'b0;
    send_pair(1, 0);
    side_in_dat[1:0] = 2'b00; side_in_vld[1:0] = 2'b11;
    repeat (3) begin
      #3;
      check(side_in_rdy[0] == 1'b0, "R7 no fire while full", side_in_rdy[0], 0);
      check(side_out_vld[2] == 1'b1 && side_out_dat[2] == 1'b1, "R12 result held", side_out_dat[2], 1);
      @(negedge clk);
    end
    side_out_rdy[2] = 1'b1;
    send_pair(0, 0);
    wait_idle(4, "R7 drained");

    // ---- copy: copy0 from W to N,E,S; N direct code = source0 (const 1) must be overridden
    cfg_v = '0;
    cfg_v[35:32] = 4'd6;
    cfg_v[51:48] = 4'd4;
    cfg_v[55:52] = 4'b0111;
    cfg_v[68]    = 1'b1;
    reconfig();
    for (int j = 0; j < 4; j++) side_req[j] = "R8";
    side_out_rdy = 4'b1101;
    for (int j = 0; j < 3; j++) q[j].push_back(1'b0);
    side_in_dat[3] = 1'b0; side_in_vld[3] = 1'b1;
    #1;
    check(side_in_rdy[3] == 1'b1, "R8 empty copy accepts", side_in_rdy[3], 1);
    @(posedge clk); @(negedge clk);
    for (int j = 0; j < 3; j++) q[j].push_back(1'b1);
    side_in_dat[3] = 1'b1;
    @(negedge clk);
    repeat (3) begin
      #3;
      check(side_in_rdy[3] == 1'b0, "R8 blocked until all taken", side_in_rdy[3], 0);
      check(side_out_vld[0] == 1'b0, "R8 N not resent / R9 direct ignored", side_out_vld[0], 0);
      check(side_out_vld[1] == 1'b1 && side_out_dat[1] == 1'b0, "R12 E copy held", side_out_vld[1], 1);
      check(side_out_vld[3] == 1'b0, "R9 W unclaimed and unrouted", side_out_vld[3], 0);
      @(negedge clk);
    end
    side_out_rdy[1] = 1'b1;
    while (1) begin
      #1;
      if (side_in_rdy[3]) break;
      @(negedge clk);
    end
    @(posedge clk); @(negedge clk);
    side_in_vld[3] = 1'b0;
    wait_idle(4, "R8 every side once");

    // ---- sources, sink, constant operand
    cfg_v = '0;
    cfg_v[15:0]  = 16'h0002;
    cfg_v[19:16] = 4'd7;
    cfg_v[39:36] = 4'd8;
    cfg_v[43:40] = 4'd5;
    cfg_v[47:44] = 4'd7;
    cfg_v[67:64] = 4'd1;
    cfg_v[69]    = 1'b1;
    cfg_v[70]    = 1'b0;
    reconfig();
    side_req[1] = "R10"; side_req[3] = "R10"; side_req[2] = "R6"; side_req[0] = "R11";
    const_on[1] = 1; const_val[1] = 0;
    const_on[2] = 1; const_val[2] = 1;
    const_on[3] = 1; const_val[3] = 1;
    side_out_rdy = 4'hF;
    side_in_vld[0] = 1'b1;
    cfg_word = '0;
    for (int i = 0; i < 12; i++) begin
      side_in_dat[0] = i[0];
      #3;
      check(side_in_rdy[0] == 1'b1, "R11 sink ready", side_in_rdy[0], 1);
      check(side_out_vld[0] == 1'b0, "R11 sink token discarded", side_out_vld[0], 0);
      check(side_out_vld[3] == 1'b1, "R2 no load without strobe", side_out_vld[3], 1);
      @(negedge clk);
    end
    side_in_vld[0] = 1'b0;
    check(const_cnt[3] > 0, "R10 source1 on W", const_cnt[3], 1);
    check(const_cnt[1] > 0, "R10 source2 on E", const_cnt[1], 1);
    check(const_cnt[2] > 0, "R6 constant operand result", const_cnt[2], 1);
    for (int j = 0; j < 4; j++) const_on[j] = 0;
    side_out_rdy = '0;

    summary();
    $finish;
  end
endmodule